// File: doc/BRIEF.md
# Audio sample FIFO pair with threshold service requests

This block holds the two sample queues of an audio serial port. The transmit queue is filled with words from the bus side and drained one sample at a time by the serial engine. The receive queue is filled by the serial engine and drained by bus reads. The block compares the fill level of each queue with a programmable threshold. The result drives a DMA service request and an optional interrupt. The DMA engine itself sits outside the block. The queues are deep enough to take a full 16-word burst with room to spare.

Transmit underrun and receive overrun set sticky flags, which can raise interrupts. On an underrun the serial side gets either zero or, with replay enabled, the previous sample again. Each queue can be emptied by its own flush strobe. Under the `SHARED_FLUSH` parameter the transmit flush instead empties both queues and the receive flush does nothing. A global enable gates every queue operation. A synchronous soft reset returns the queues, the flags, the output sample and the thresholds to their reset state.

Top module: `aud_fifo_svc`

## Requirements
- R1: After `rst_n` is released, both levels are 0, `ser_tx_data` is 0, both sticky flags are 0 and, with `enable` low, both DMA requests are 0.
- R2: Words written with `bus_wr` leave the transmit queue in write order. Each `ser_tx_req` with data present places the oldest word on `ser_tx_data` in the cycle after the request.
- R3: `bus_rdata` always shows the oldest received sample, and a `bus_rd` removes it. Samples arrive through `ser_rx_valid` in the order they were received.
- R4: Each queue holds `DEPTH` (default 32) samples. A write to a full transmit queue is dropped, and its level never exceeds `DEPTH`.
- R5: `tx_dreq` is high exactly when `enable` and `tx_dma_en` are high and the transmit level is at or below the transmit threshold.
- R6: `rx_dreq` is high exactly when `enable` and `rx_dma_en` are high and the receive level is nonzero and at or above the receive threshold.
- R7: The thresholds reset to 8 (transmit) and 7 (receive). A `thr_load` pulse copies `tx_thr_in` and `rx_thr_in` into them.
- R8: With `SHARED_FLUSH` = 0 and `enable` high, `tx_flush` empties only the transmit queue and `rx_flush` empties only the receive queue. A flush takes priority over a same-cycle push or pop on that queue.
- R9: With `SHARED_FLUSH` = 1, `tx_flush` empties both queues and `rx_flush` leaves the receive level unchanged.
- R10: A `ser_tx_req` on an empty transmit queue sets the sticky `tx_under` flag. `ser_tx_data` then becomes 0 when `replay_last` is low and keeps its previous sample when `replay_last` is high.
- R11: A received sample arriving at a full receive queue is dropped and sets the sticky `rx_over` flag. `clr_under` and `clr_over` clear their flags unless a new event sets the flag in the same cycle.
- R12: Each interrupt is its enable ANDed with its condition. `irq_under` follows `tx_under` and `irq_over` follows `rx_over`. `irq_txreq` is high when `enable` is high and the transmit level is at or below its threshold. `irq_rxreq` is high when `enable` is high and the receive level is nonzero and at or above its threshold.
- R13: While `enable` is low, writes, reads, pushes, pops and flushes change nothing and both DMA requests stay low. `soft_rst` empties both queues, clears both flags, zeroes `ser_tx_data` and restores the default thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global operation enable |
| soft_rst | input | 1 | Synchronous clear of queues, flags and thresholds |
| thr_load | input | 1 | Load both thresholds |
| tx_thr_in | input | TX_THR_W | New transmit threshold |
| rx_thr_in | input | RX_THR_W | New receive threshold |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| replay_last | input | 1 | Repeat the last sample on underrun |
| ie_under | input | 1 | Underrun interrupt enable |
| ie_over | input | 1 | Overrun interrupt enable |
| ie_txreq | input | 1 | Transmit service interrupt enable |
| ie_rxreq | input | 1 | Receive service interrupt enable |
| tx_flush | input | 1 | Transmit flush strobe |
| rx_flush | input | 1 | Receive flush strobe |
| clr_under | input | 1 | Clear the underrun flag |
| clr_over | input | 1 | Clear the overrun flag |
| bus_wr | input | 1 | Bus write into the transmit queue |
| bus_wdata | input | DW | Bus write word |
| bus_rd | input | 1 | Bus read from the receive queue |
| bus_rdata | output | DW | Oldest receive sample |
| ser_tx_req | input | 1 | Serial engine takes one transmit sample |
| ser_tx_data | output | DW | Current transmit sample |
| ser_rx_valid | input | 1 | Serial engine delivers one sample |
| ser_rx_data | input | DW | Delivered sample |
| tx_dreq | output | 1 | Transmit DMA service request |
| rx_dreq | output | 1 | Receive DMA service request |
| irq_under | output | 1 | Underrun interrupt |
| irq_over | output | 1 | Overrun interrupt |
| irq_txreq | output | 1 | Transmit service interrupt |
| irq_rxreq | output | 1 | Receive service interrupt |
| tx_under | output | 1 | Sticky underrun flag |
| rx_over | output | 1 | Sticky overrun flag |
| tx_level | output | $clog2(DEPTH)+1 | Transmit fill level |
| rx_level | output | $clog2(DEPTH)+1 | Receive fill level |

## Verification
The properties take every control input to be a clean 0 or 1 sampled at the rising edge. They also treat a soft reset as overriding anything else in that cycle, so their antecedents exclude it. The bench changes every input shortly after a rising edge and holds it until the next one. In the random phase the flushes and the soft reset are rare, so the queues spend long stretches near full and near empty, where the full-drop, replay and stickiness properties come into play. Because the replay property compares against the previous cycle's sample, it only means something once at least one sample has left the queue. The stimulus reaches that point before it first empties the queue with replay enabled.

// File: rtl/aud_pkg.sv
package aud_pkg;
   localparam int TX_THR_DEF = 8;
   localparam int RX_THR_DEF = 7;
   localparam int MIN_DEPTH  = 16;
endpackage

// File: rtl/aud_sfifo.sv
module aud_sfifo #(
   parameter int DW    = 24,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [LW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign level   = wptr - rptr;
   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;
   assign head    = mem[rptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr[AW-1:0]] <= wdata;
   end
endmodule

// File: rtl/aud_flush_route.sv
module aud_flush_route #(
   parameter bit SHARED = 1'b0
) (
   input  logic enable,
   input  logic soft_rst,
   input  logic tx_flush,
   input  logic rx_flush,
   output logic tx_clr,
   output logic rx_clr
);
   logic tx_hit, rx_hit;
   assign tx_hit = enable && tx_flush;
   assign rx_hit = enable && rx_flush;

   generate
      if (SHARED) begin : g_shared
         assign tx_clr = soft_rst || tx_hit;
         assign rx_clr = soft_rst || tx_hit;
      end else begin : g_split
         assign tx_clr = soft_rst || tx_hit;
         assign rx_clr = soft_rst || rx_hit;
      end
   endgenerate
endmodule

// File: rtl/aud_svc_req.sv
module aud_svc_req #(
   parameter int LW          = 6,
   parameter int TW          = 4,
   parameter bit AT_OR_ABOVE = 1'b0,
   localparam int CW         = (LW > TW) ? LW : TW
) (
   input  logic [LW-1:0] level,
   input  logic [TW-1:0] thr,
   input  logic          enable,
   input  logic          dma_en,
   input  logic          irq_en,
   output logic          dreq,
   output logic          irq
);
   logic [CW-1:0] lvl_x, thr_x;
   logic          cond;

   assign lvl_x = CW'(level);
   assign thr_x = CW'(thr);

   generate
      if (AT_OR_ABOVE) begin : g_fill
         assign cond = (lvl_x >= thr_x) && (lvl_x != '0);
      end else begin : g_drain
         assign cond = (lvl_x <= thr_x);
      end
   endgenerate

   assign dreq = enable && dma_en && cond;
   assign irq  = enable && irq_en && cond;
endmodule

// File: rtl/aud_fifo_svc.sv
module aud_fifo_svc
   import aud_pkg::*;
#(
   parameter int DW           = 24,
   parameter int DEPTH        = 32,
   parameter int TX_THR_W     = 5,
   parameter int RX_THR_W     = 4,
   parameter bit SHARED_FLUSH = 1'b0,
   localparam int LVW         = $clog2(DEPTH) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                soft_rst,
   input  logic                thr_load,
   input  logic [TX_THR_W-1:0] tx_thr_in,
   input  logic [RX_THR_W-1:0] rx_thr_in,
   input  logic                tx_dma_en,
   input  logic                rx_dma_en,
   input  logic                replay_last,
   input  logic                ie_under,
   input  logic                ie_over,
   input  logic                ie_txreq,
   input  logic                ie_rxreq,
   input  logic                tx_flush,
   input  logic                rx_flush,
   input  logic                clr_under,
   input  logic                clr_over,
   input  logic                bus_wr,
   input  logic [DW-1:0]       bus_wdata,
   input  logic                bus_rd,
   output logic [DW-1:0]       bus_rdata,
   input  logic                ser_tx_req,
   output logic [DW-1:0]       ser_tx_data,
   input  logic                ser_rx_valid,
   input  logic [DW-1:0]       ser_rx_data,
   output logic                tx_dreq,
   output logic                rx_dreq,
   output logic                irq_under,
   output logic                irq_over,
   output logic                irq_txreq,
   output logic                irq_rxreq,
   output logic                tx_under,
   output logic                rx_over,
   output logic [LVW-1:0]      tx_level,
   output logic [LVW-1:0]      rx_level
);
   generate
      if (TX_THR_W < 4 || TX_THR_W > 5) begin : g_bad_txw
         $error("TX_THR_W must be 4 or 5");
      end
      if (RX_THR_W != 4) begin : g_bad_rxw
         $error("RX_THR_W must be 4");
      end
      if (DEPTH < MIN_DEPTH || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 16");
      end
   endgenerate

   logic                tx_clr, rx_clr;
   logic                tx_full, tx_empty, rx_full, rx_empty;
   logic [DW-1:0]       tx_head;
   logic [TX_THR_W-1:0] tx_thr;
   logic [RX_THR_W-1:0] rx_thr;
   logic                tx_pop, under_evt, over_evt;

   aud_flush_route #(.SHARED(SHARED_FLUSH)) u_route (
      .enable  (enable),
      .soft_rst(soft_rst),
      .tx_flush(tx_flush),
      .rx_flush(rx_flush),
      .tx_clr  (tx_clr),
      .rx_clr  (rx_clr)
   );

   aud_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tx_clr),
      .push (enable && bus_wr),
      .pop  (tx_pop),
      .wdata(bus_wdata),
      .head (tx_head),
      .level(tx_level),
      .full (tx_full),
      .empty(tx_empty)
   );

   aud_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (rx_clr),
      .push (enable && ser_rx_valid),
      .pop  (enable && bus_rd),
      .wdata(ser_rx_data),
      .head (bus_rdata),
      .level(rx_level),
      .full (rx_full),
      .empty(rx_empty)
   );

   assign tx_pop    = enable && ser_tx_req;
   assign under_evt = tx_pop && tx_empty && !tx_clr;
   assign over_evt  = enable && ser_rx_valid && rx_full && !rx_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_tx_data <= '0;
      end else if (soft_rst) begin
         ser_tx_data <= '0;
      end else if (tx_pop && !tx_clr) begin
         if (!tx_empty)         ser_tx_data <= tx_head;
         else if (!replay_last) ser_tx_data <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_under <= 1'b0;
         rx_over  <= 1'b0;
      end else if (soft_rst) begin
         tx_under <= 1'b0;
         rx_over  <= 1'b0;
      end else begin
         if (under_evt)      tx_under <= 1'b1;
         else if (clr_under) tx_under <= 1'b0;
         if (over_evt)       rx_over  <= 1'b1;
         else if (clr_over)  rx_over  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_thr <= TX_THR_W'(TX_THR_DEF);
         rx_thr <= RX_THR_W'(RX_THR_DEF);
      end else if (soft_rst) begin
         tx_thr <= TX_THR_W'(TX_THR_DEF);
         rx_thr <= RX_THR_W'(RX_THR_DEF);
      end else if (thr_load) begin
         tx_thr <= tx_thr_in;
         rx_thr <= rx_thr_in;
      end
   end

   aud_svc_req #(.LW(LVW), .TW(TX_THR_W), .AT_OR_ABOVE(1'b0)) u_txreq (
      .level (tx_level),
      .thr   (tx_thr),
      .enable(enable),
      .dma_en(tx_dma_en),
      .irq_en(ie_txreq),
      .dreq  (tx_dreq),
      .irq   (irq_txreq)
   );

   aud_svc_req #(.LW(LVW), .TW(RX_THR_W), .AT_OR_ABOVE(1'b1)) u_rxreq (
      .level (rx_level),
      .thr   (rx_thr),
      .enable(enable),
      .dma_en(rx_dma_en),
      .irq_en(ie_rxreq),
      .dreq  (rx_dreq),
      .irq   (irq_rxreq)
   );

   assign irq_under = ie_under && tx_under;
   assign irq_over  = ie_over && rx_over;
endmodule

// File: rtl/aud_fifo_chk.sv
module aud_fifo_chk #(
   parameter int DW    = 24,
   parameter int DEPTH = 32,
   localparam int LVW  = $clog2(DEPTH) + 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           enable,
   input logic           soft_rst,
   input logic           replay_last,
   input logic           tx_flush,
   input logic           rx_flush,
   input logic           clr_under,
   input logic           clr_over,
   input logic           bus_wr,
   input logic           ser_tx_req,
   input logic [DW-1:0]  ser_tx_data,
   input logic           tx_dreq,
   input logic           rx_dreq,
   input logic           tx_under,
   input logic           rx_over,
   input logic [LVW-1:0] tx_level,
   input logic [LVW-1:0] rx_level
);
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LVW'(DEPTH) && rx_level <= LVW'(DEPTH)); // R4

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      enable && bus_wr && !ser_tx_req && !tx_flush && !soft_rst && tx_level == LVW'(DEPTH)
      |=> tx_level == LVW'(DEPTH)); // R4

   AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      enable && tx_flush |=> tx_level == '0); // R8

   AST_REPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      enable && replay_last && ser_tx_req && tx_level == '0 && !tx_flush && !soft_rst
      |=> $stable(ser_tx_data)); // R10

   AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_under && !clr_under && !soft_rst |=> tx_under); // R10

   AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_over && !clr_over && !soft_rst |=> rx_over); // R11

   AST_IDLE_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !tx_dreq && !rx_dreq); // R13

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !soft_rst |=> $stable(tx_level) && $stable(rx_level)); // R13
endmodule

bind aud_fifo_svc aud_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .soft_rst   (soft_rst),
   .replay_last(replay_last),
   .tx_flush   (tx_flush),
   .rx_flush   (rx_flush),
   .clr_under  (clr_under),
   .clr_over   (clr_over),
   .bus_wr     (bus_wr),
   .ser_tx_req (ser_tx_req),
   .ser_tx_data(ser_tx_data),
   .tx_dreq    (tx_dreq),
   .rx_dreq    (rx_dreq),
   .tx_under   (tx_under),
   .rx_over    (rx_over),
   .tx_level   (tx_level),
   .rx_level   (rx_level)
);

// File: tb/sim_aud_fifo_svc.sv
module sim_aud_fifo_svc;
   localparam int DW = 24, DEPTH = 32, TW = 5, RW = 4, LVW = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 0, soft_rst = 0, thr_load = 0;
   logic [TW-1:0] tx_thr_in = '0;
   logic [RW-1:0] rx_thr_in = '0;
   logic tx_dma_en = 0, rx_dma_en = 0, replay_last = 0;
   logic ie_under = 0, ie_over = 0, ie_txreq = 0, ie_rxreq = 0;
   logic tx_flush = 0, rx_flush = 0, clr_under = 0, clr_over = 0;
   logic bus_wr = 0, bus_rd = 0, ser_tx_req = 0, ser_rx_valid = 0;
   logic [DW-1:0] bus_wdata = '0, ser_rx_data = '0;

   logic [DW-1:0] bus_rdata, ser_tx_data, b_rdata, b_txd;
   logic tx_dreq, rx_dreq, irq_under, irq_over, irq_txreq, irq_rxreq, tx_under, rx_over;
   logic b_txdr, b_rxdr, b_iu, b_io, b_it, b_ir, b_tu, b_ro;
   logic [LVW-1:0] tx_level, rx_level, b_txl, b_rxl;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10ns clk = ~clk;

   aud_fifo_svc #(.DW(DW), .DEPTH(DEPTH), .TX_THR_W(TW), .RX_THR_W(RW), .SHARED_FLUSH(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst), .thr_load(thr_load),
      .tx_thr_in(tx_thr_in), .rx_thr_in(rx_thr_in), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
      .replay_last(replay_last), .ie_under(ie_under), .ie_over(ie_over), .ie_txreq(ie_txreq),
      .ie_rxreq(ie_rxreq), .tx_flush(tx_flush), .rx_flush(rx_flush), .clr_under(clr_under),
      .clr_over(clr_over), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .ser_tx_req(ser_tx_req), .ser_tx_data(ser_tx_data),
      .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
      .irq_under(irq_under), .irq_over(irq_over), .irq_txreq(irq_txreq), .irq_rxreq(irq_rxreq),
      .tx_under(tx_under), .rx_over(rx_over), .tx_level(tx_level), .rx_level(rx_level));

   // second copy in the shared-flush variant, same stimulus
   aud_fifo_svc #(.DW(DW), .DEPTH(DEPTH), .TX_THR_W(TW), .RX_THR_W(RW), .SHARED_FLUSH(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst), .thr_load(thr_load),
      .tx_thr_in(tx_thr_in), .rx_thr_in(rx_thr_in), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
      .replay_last(replay_last), .ie_under(ie_under), .ie_over(ie_over), .ie_txreq(ie_txreq),
      .ie_rxreq(ie_rxreq), .tx_flush(tx_flush), .rx_flush(rx_flush), .clr_under(clr_under),
      .clr_over(clr_over), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_rdata(b_rdata), .ser_tx_req(ser_tx_req), .ser_tx_data(b_txd),
      .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data), .tx_dreq(b_txdr), .rx_dreq(b_rxdr),
      .irq_under(b_iu), .irq_over(b_io), .irq_txreq(b_it), .irq_rxreq(b_ir),
      .tx_under(b_tu), .rx_over(b_ro), .tx_level(b_txl), .rx_level(b_rxl));

   // ---------------- behavioural reference of u0 ----------------
   int txq[$], rxq[$];
   int m_txo, m_thr_tx, m_thr_rx;
   bit m_tur, m_ror;

   always @(posedge clk) begin : model
      bit st, sr;
      int pre;
      st = 0; sr = 0;
      if (!rst_n || soft_rst) begin
         txq.delete(); rxq.delete();
         m_txo = 0; m_thr_tx = 8; m_thr_rx = 7; m_tur = 0; m_ror = 0;
      end else begin
         if (enable) begin
            if (tx_flush) txq.delete();
            else begin
               pre = txq.size();
               if (ser_tx_req) begin
                  if (pre > 0) m_txo = txq.pop_front();
                  else begin st = 1; if (!replay_last) m_txo = 0; end
               end
               if (bus_wr && pre < DEPTH) txq.push_back(int'(bus_wdata));
            end
            if (rx_flush) rxq.delete();
            else begin
               pre = rxq.size();
               if (bus_rd && pre > 0) void'(rxq.pop_front());
               if (ser_rx_valid) begin
                  if (pre == DEPTH) sr = 1;
                  else rxq.push_back(int'(ser_rx_data));
               end
            end
         end
         if (thr_load) begin m_thr_tx = int'(tx_thr_in); m_thr_rx = int'(rx_thr_in); end
         if (st) m_tur = 1; else if (clr_under) m_tur = 0;
         if (sr) m_ror = 1; else if (clr_over) m_ror = 0;
      end
   end

   task automatic cmp(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int tl, rl;
         tl = txq.size(); rl = rxq.size();
         cmp("R4 tx_level", int'(tx_level), tl);
         cmp("R3 rx_level", int'(rx_level), rl);
         cmp("R2 ser_tx_data", int'(ser_tx_data), m_txo);
         if (rl > 0) cmp("R3 bus_rdata", int'(bus_rdata), rxq[0]);
         cmp("R5 tx_dreq", int'(tx_dreq), int'(enable && tx_dma_en && tl <= m_thr_tx));
         cmp("R6 rx_dreq", int'(rx_dreq), int'(enable && rx_dma_en && rl >= m_thr_rx && rl != 0));
         cmp("R10 tx_under", int'(tx_under), int'(m_tur));
         cmp("R11 rx_over", int'(rx_over), int'(m_ror));
         cmp("R12 irq_under", int'(irq_under), int'(ie_under && m_tur));
         cmp("R12 irq_over", int'(irq_over), int'(ie_over && m_ror));
         cmp("R12 irq_txreq", int'(irq_txreq), int'(enable && ie_txreq && tl <= m_thr_tx));
         cmp("R12 irq_rxreq", int'(irq_rxreq), int'(enable && ie_rxreq && rl >= m_thr_rx && rl != 0));
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2ns;
   endtask

   task automatic wr_tx(int v);
      bus_wr = 1; bus_wdata = DW'(v); step(1); bus_wr = 0;
   endtask

   task automatic push_rx(int v);
      ser_rx_valid = 1; ser_rx_data = DW'(v); step(1); ser_rx_valid = 0;
   endtask

   task automatic pop_tx();
      ser_tx_req = 1; step(1); ser_tx_req = 0;
   endtask

   task automatic rd_rx();
      bus_rd = 1; step(1); bus_rd = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #3800us;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      // R1 reset state
      cmp("R1 tx_level", int'(tx_level), 0);
      cmp("R1 rx_level", int'(rx_level), 0);
      cmp("R1 ser_tx_data", int'(ser_tx_data), 0);
      cmp("R1 flags", int'({tx_under, rx_over}), 0);
      cmp("R1 dreq", int'({tx_dreq, rx_dreq}), 0);

      // R7 default thresholds seen through the requests (R5, R6)
      enable = 1; tx_dma_en = 1; rx_dma_en = 1;
      for (int i = 0; i < 8; i++) wr_tx(100 + i);
      cmp("R7 tx_dreq at level 8", int'(tx_dreq), 1);
      wr_tx(108);
      cmp("R5 tx_dreq at level 9", int'(tx_dreq), 0);
      for (int i = 0; i < 6; i++) push_rx(200 + i);
      cmp("R6 rx_dreq at level 6", int'(rx_dreq), 0);
      push_rx(206);
      cmp("R7 rx_dreq at level 7", int'(rx_dreq), 1);
      rx_dma_en = 0; step(1);
      cmp("R6 rx_dreq gated", int'(rx_dreq), 0);

      // R2 order
      pop_tx();
      cmp("R2 first word", int'(ser_tx_data), 100);
      pop_tx(); pop_tx();
      cmp("R2 third word", int'(ser_tx_data), 102);
      // R3 order
      cmp("R3 head", int'(bus_rdata), 200);
      rd_rx();
      cmp("R3 next head", int'(bus_rdata), 201);

      // R4 full drop: 6 held, write 30 more
      for (int i = 0; i < 30; i++) wr_tx(300 + i);
      cmp("R4 capped level", int'(tx_level), DEPTH);
      for (int i = 0; i < 32; i++) pop_tx();
      cmp("R4 last accepted word", int'(ser_tx_data), 325);

      // R10 underrun without and with replay
      pop_tx();
      cmp("R10 zero on underrun", int'(ser_tx_data), 0);
      cmp("R10 flag set", int'(tx_under), 1);
      ie_under = 1; step(1);
      cmp("R12 irq_under", int'(irq_under), 1);
      clr_under = 1; step(1); clr_under = 0;
      cmp("R11 clr_under", int'(tx_under), 0);
      replay_last = 1;
      wr_tx(400); pop_tx(); pop_tx();
      cmp("R10 replay keeps sample", int'(ser_tx_data), 400);
      cmp("R10 flag again", int'(tx_under), 1);

      // R11 overrun: 6 held, push 30
      for (int i = 0; i < 30; i++) push_rx(500 + i);
      cmp("R11 rx capped", int'(rx_level), DEPTH);
      cmp("R11 rx_over set", int'(rx_over), 1);
      for (int i = 0; i < 31; i++) rd_rx();
      cmp("R11 last kept sample", int'(bus_rdata), 525);
      rd_rx();
      clr_over = 1; step(1); clr_over = 0;
      cmp("R11 clr_over", int'(rx_over), 0);

      // R8 / R9 flush routing
      for (int i = 0; i < 5; i++) wr_tx(600 + i);
      for (int i = 0; i < 6; i++) push_rx(700 + i);
      rx_flush = 1; step(1); rx_flush = 0;
      cmp("R8 rx emptied", int'(rx_level), 0);
      cmp("R8 tx kept", int'(tx_level), 5);
      cmp("R9 shared rx kept", int'(b_rxl), 6);
      tx_flush = 1; step(1); tx_flush = 0;
      cmp("R8 tx emptied", int'(tx_level), 0);
      cmp("R9 shared tx emptied", int'(b_txl), 0);
      cmp("R9 shared rx emptied", int'(b_rxl), 0);

      // R7 / R12 loaded thresholds
      ie_txreq = 1; ie_rxreq = 1;
      tx_thr_in = 2; rx_thr_in = 1; thr_load = 1; step(1); thr_load = 0;
      cmp("R12 irq_rxreq empty", int'(irq_rxreq), 0);
      push_rx(800);
      cmp("R12 irq_rxreq level 1", int'(irq_rxreq), 1);
      wr_tx(1); wr_tx(2); wr_tx(3);
      cmp("R7 loaded tx threshold", int'(irq_txreq), 0);

      // R13 enable low, then soft reset
      enable = 0; bus_wr = 1; ser_rx_valid = 1; bus_rd = 1; ser_tx_req = 1; tx_flush = 1;
      step(5);
      bus_wr = 0; ser_rx_valid = 0; bus_rd = 0; ser_tx_req = 0; tx_flush = 0;
      cmp("R13 tx held", int'(tx_level), 3);
      cmp("R13 rx held", int'(rx_level), 1);
      cmp("R13 dreq low", int'(tx_dreq), 0);
      enable = 1; soft_rst = 1; step(1); soft_rst = 0;
      cmp("R13 soft reset tx", int'(tx_level), 0);
      cmp("R13 soft reset flag", int'(tx_under), 0);
      cmp("R13 soft reset data", int'(ser_tx_data), 0);

      // mixed random traffic against the reference
      for (int c = 0; c < 4000; c++) begin
         bus_wr       = ($urandom_range(0, 99) < 45);
         bus_wdata    = DW'($urandom);
         bus_rd       = ($urandom_range(0, 99) < 40);
         ser_tx_req   = ($urandom_range(0, 99) < 40);
         ser_rx_valid = ($urandom_range(0, 99) < 45);
         ser_rx_data  = DW'($urandom);
         enable       = ($urandom_range(0, 99) < 95);
         tx_flush     = ($urandom_range(0, 999) < 8);
         rx_flush     = ($urandom_range(0, 999) < 8);
         soft_rst     = ($urandom_range(0, 999) < 2);
         thr_load     = ($urandom_range(0, 99) < 3);
         tx_thr_in    = TW'($urandom);
         rx_thr_in    = RW'($urandom);
         clr_under    = ($urandom_range(0, 99) < 5);
         clr_over     = ($urandom_range(0, 99) < 5);
         replay_last  = ($urandom_range(0, 99) < 50);
         tx_dma_en    = ($urandom_range(0, 99) < 80);
         rx_dma_en    = ($urandom_range(0, 99) < 80);
         ie_under     = $urandom_range(0, 1);
         ie_over      = $urandom_range(0, 1);
         step(1);
      end
      bus_wr = 0; bus_rd = 0; ser_tx_req = 0; ser_rx_valid = 0;
      tx_flush = 0; rx_flush = 0; soft_rst = 0; thr_load = 0;
      step(2);
      finish_run();
   end
endmodule